// File: doc/BRIEF.md
# Hard-Decision Viterbi Metric Engine (Branch Metric and Add-Compare-Select)

This block is the metric half of a 16-state Viterbi decoder for a rate 1/2, constraint-length-5 convolutional code. The code generators are 35 and 23 in octal. On each qualified cycle it takes one 2-bit hard-decision symbol. From that symbol it forms the Hamming-distance branch metric of every trellis branch. It then runs add-compare-select for all sixteen states and updates its internal path metrics.

On the cycle after each accepted symbol it presents two results. The first is a 16-bit vector with one survivor decision per state. The second is the index of the state whose updated path metric is smallest. A separate traceback unit stores the decision vectors and starts its walk back from the reported best state. Path metrics are 8-bit unsigned. At every step they are renormalized by subtracting the smallest metric of the previous step, so a stream of any length never wraps them.

Top module: `vit_metric_core`

## Requirements
- R1: A state is the last four input bits, with the newest bit in bit 3. State s is reached from predecessors (2s mod 16) and (2s mod 16)+1, and the input bit on that branch is bit 3 of s.
- R2: A branch whose 5-bit encoder register is e = {s[3], predecessor} expects the code pair (parity(e AND 35o), parity(e AND 23o)). The first bit of the pair is compared with in_sym[1] and the second with in_sym[0]. The branch metric is the number of mismatching bits (0, 1 or 2).
- R3: The new metric of each state is the smaller of its two candidates, each candidate being predecessor metric plus branch metric. dec_vec[s] is 1 when the odd predecessor survives and 0 when the even one survives.
- R4: When the two candidates are equal, the even predecessor is chosen and dec_vec[s] is 0.
- R5: best_state is the lowest state index among the states holding the smallest updated path metric.
- R6: After reset, state 0 holds metric 0 and every other state holds 32.
- R7: out_valid is 1 exactly one clock after a cycle with in_valid high and 0 otherwise. dec_vec and best_state belong to that symbol.
- R8: While in_valid is 0, in_sym is ignored. The path metrics, dec_vec and best_state do not change.
- R9: Metrics are renormalized by the previous minimum each step. Over an arbitrarily long noisy stream, decisions and best_state match an unbounded reference.
- R10: On an error-free encoded stream started from reset, best_state equals the encoder's state after each symbol.
- R11: While reset is high, out_valid, dec_vec and best_state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies in_sym for this cycle |
| in_sym | input | 2 | Hard-decision received pair (bit 1 for the first generator, bit 0 for the second) |
| out_valid | output | 1 | dec_vec and best_state hold a new step |
| dec_vec | output | 16 | Survivor decision per state |
| best_state | output | 4 | State with the smallest updated metric |

## Verification
The bench builds the block with its default parameters: K=5, generators 35 and 23 octal, 8-bit metrics and an initial bias of 32. With that bias the first steps after reset produce many equal candidates, so the tie rule is exercised heavily. Because the metric width is only 8 bits, a noisy stream of about two thousand symbols would wrap the metrics within the run if renormalization were wrong. An unnormalized integer reference model therefore exposes any normalization fault. An error-free phase ties best_state to a bench-side encoder, and idle gaps filled with garbage symbols probe the hold behaviour.

// File: rtl/vit_pkg.sv
package vit_pkg;
  // parity of the generator taps applied to a register value
  function automatic logic tap_parity(input int unsigned gen, input int unsigned reg_v);
    int unsigned x;
    logic p;
    x = gen & reg_v;
    p = 1'b0;
    for (int i = 0; i < 32; i++) p = p ^ x[i];
    return p;
  endfunction
endpackage

// File: rtl/vit_bmu.sv
// Branch metric table: Hamming distance of the received pair to each code pair
module vit_bmu (
  input  logic [1:0] rx_sym,
  output logic [1:0] bm_tab [4]
);
  always_comb begin
    for (int c = 0; c < 4; c++) begin
      logic [1:0] diff;
      diff = rx_sym ^ 2'(c);
      bm_tab[c] = {1'b0, diff[1]} + {1'b0, diff[0]};
    end
  end
endmodule

// File: rtl/vit_acs.sv
// One add-compare-select cell with renormalization
module vit_acs #(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [MW-1:0] pm_even,
  input  logic [MW-1:0] pm_odd,
  input  logic [1:0]    bm_even,
  input  logic [1:0]    bm_odd,
  input  logic [MW-1:0] norm,
  output logic [MW-1:0] pm_out,
  output logic          pick_odd
);
  logic [MW:0] sum_e, sum_o, sel;

  always_comb begin
    sum_e    = {1'b0, pm_even} + {{(MW-1){1'b0}}, bm_even};
    sum_o    = {1'b0, pm_odd}  + {{(MW-1){1'b0}}, bm_odd};
    pick_odd = (sum_o < sum_e);
    sel      = pick_odd ? sum_o : sum_e;
    pm_out   = MW'(sel - {1'b0, norm});
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) step |-> !sel[MW]);
  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) step |-> (sel >= {1'b0, norm}));
  // R4
  tie_even_chk: assert property (@(posedge clk) disable iff (rst)
    (step && sum_e == sum_o) |-> (pm_out == MW'(sum_e - {1'b0, norm})) && !pick_odd);
endmodule

// File: rtl/vit_minfind.sv
// Smallest value and its lowest index
module vit_minfind #(
  parameter int N  = 16,
  parameter int MW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [MW-1:0] vals [N],
  output logic [IW-1:0] min_idx,
  output logic [MW-1:0] min_val
);
  always_comb begin
    min_idx = '0;
    min_val = vals[0];
    for (int i = 1; i < N; i++) begin
      if (vals[i] < min_val) begin
        min_val = vals[i];
        min_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vit_metric_core.sv
module vit_metric_core #(
  parameter int K       = 5,
  parameter int GEN_A   = 'o35,
  parameter int GEN_B   = 'o23,
  parameter int MW      = 8,
  parameter int INIT_PM = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [1:0]            in_sym,
  output logic                  out_valid,
  output logic [(1<<(K-1))-1:0] dec_vec,
  output logic [K-2:0]          best_state
);
  import vit_pkg::*;

  localparam int SW = K - 1;
  localparam int NS = 1 << SW;

  logic [MW-1:0] pm_q   [NS];
  logic [MW-1:0] pm_nxt [NS];
  logic [MW-1:0] min_q;
  logic [NS-1:0] dec_nxt;
  logic [1:0]    bm_tab [4];
  logic [SW-1:0] best_idx;
  logic [MW-1:0] best_val;

  vit_bmu u_bmu (.rx_sym(in_sym), .bm_tab(bm_tab));

  for (genvar s = 0; s < NS; s++) begin : g_state
    localparam int PE   = (2 * s) % NS;
    localparam int PO   = PE + 1;
    localparam int UBIT = s >> (SW - 1);
    localparam int EE   = (UBIT << SW) | PE;
    localparam int EO   = (UBIT << SW) | PO;
    localparam int CE   = (int'(tap_parity(GEN_A, EE)) << 1) | int'(tap_parity(GEN_B, EE));
    localparam int CO   = (int'(tap_parity(GEN_A, EO)) << 1) | int'(tap_parity(GEN_B, EO));

    vit_acs #(.MW(MW)) u_acs (
      .clk     (clk),
      .rst     (rst),
      .step    (in_valid),
      .pm_even (pm_q[PE]),
      .pm_odd  (pm_q[PO]),
      .bm_even (bm_tab[CE]),
      .bm_odd  (bm_tab[CO]),
      .norm    (min_q),
      .pm_out  (pm_nxt[s]),
      .pick_odd(dec_nxt[s])
    );

    // R5
    best_le_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (pm_q[best_state] <= pm_q[s]));
  end

  vit_minfind #(.N(NS), .MW(MW)) u_min (
    .vals   (pm_nxt),
    .min_idx(best_idx),
    .min_val(best_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) pm_q[i] <= (i == 0) ? '0 : MW'(INIT_PM);
      min_q      <= '0;
      out_valid  <= 1'b0;
      dec_vec    <= '0;
      best_state <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        for (int i = 0; i < NS; i++) pm_q[i] <= pm_nxt[i];
        min_q      <= best_val;
        dec_vec    <= dec_nxt;
        best_state <= best_idx;
      end
    end
  end

  // R7
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(dec_vec) && $stable(best_state) && $stable(min_q)));
endmodule

// File: tb/vit_metric_core_tb.sv
module vit_metric_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_sym = '0;
  logic        out_valid;
  logic [15:0] dec_vec;
  logic [3:0]  best_state;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  vit_metric_core dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym(in_sym),
    .out_valid(out_valid), .dec_vec(dec_vec), .best_state(best_state)
  );

  // reference model (unbounded integers, no renormalization)
  int ref_pm [16];
  logic [3:0] enc_st;
  logic [15:0] q_dec [$];
  logic [3:0]  q_best [$];
  int          q_trk [$];

  function automatic logic par(input int v);
    logic p = 1'b0;
    for (int i = 0; i < 5; i++) p = p ^ v[i];
    return p;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) ref_pm[i] = (i == 0) ? 0 : 32;
    enc_st = '0;
  endtask

  task automatic model_step(input logic [1:0] rx, input int trk);
    int nw [16];
    logic [15:0] d;
    int bi;
    for (int s = 0; s < 16; s++) begin
      int pe, po, ue, ce, co, me, mo;
      pe = (2 * s) % 16;
      po = pe + 1;
      ue = ((s >> 3) << 4) | pe;
      ce = {30'd0, par(ue & 'o35), par(ue & 'o23)};
      co = {30'd0, par((ue | 1) & 'o35), par((ue | 1) & 'o23)};
      me = ref_pm[pe] + int'(rx[1] ^ ce[1]) + int'(rx[0] ^ ce[0]);
      mo = ref_pm[po] + int'(rx[1] ^ co[1]) + int'(rx[0] ^ co[0]);
      d[s] = (mo < me);
      nw[s] = (mo < me) ? mo : me;
    end
    bi = 0;
    for (int s = 1; s < 16; s++) if (nw[s] < nw[bi]) bi = s;
    for (int s = 0; s < 16; s++) ref_pm[s] = nw[s];
    q_dec.push_back(d);
    q_best.push_back(4'(bi));
    q_trk.push_back(trk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one symbol with in_valid high
  task automatic send(input logic [1:0] rx, input int trk);
    @(negedge clk);
    in_valid = 1'b1;
    in_sym   = rx;
    model_step(rx, trk);
    @(negedge clk);
    in_valid = 1'b0;
    in_sym   = 2'($urandom);   // garbage while idle (R8)
  endtask

  task automatic send_burst(input logic [1:0] rx, input int trk);
    @(negedge clk);
    in_valid = 1'b1;
    in_sym   = rx;
    model_step(rx, trk);
  endtask

  // encoder model: returns code pair for input bit u, advances state
  function automatic logic [1:0] encode(input logic u);
    int r;
    r = {27'd0, u, enc_st};
    enc_st = {u, enc_st[3:1]};
    return {par(r & 'o35), par(r & 'o23)};
  endfunction

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (q_dec.size() == 0) begin
          check(1'b0, "R7 unexpected out_valid", 1, 0);
        end else begin
          logic [15:0] ed;
          logic [3:0]  eb;
          int          et;
          ed = q_dec.pop_front();
          eb = q_best.pop_front();
          et = q_trk.pop_front();
          check(dec_vec == ed, "R1,R2,R3,R4,R6,R8,R9 decisions", int'(dec_vec), int'(ed));
          check(best_state == eb, "R5,R9 best_state", int'(best_state), int'(eb));
          if (et >= 0) check(best_state == 4'(et), "R10 tracks encoder", int'(best_state), et);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    in_sym = 2'b11;
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R11 out_valid in reset", int'(out_valid), 0);
    check(dec_vec == '0, "R11 dec_vec in reset", int'(dec_vec), 0);
    check(best_state == '0, "R11 best_state in reset", int'(best_state), 0);
    rst = 1'b0;
    model_reset();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    model_reset();
    do_reset();

    // first step after reset: exercises initial metrics and ties (R6, R4)
    send(2'b00, -1);
    send(2'b11, -1);

    // error-free encoded stream from reset, back to back (R10, R1, R2)
    do_reset();
    for (int i = 0; i < 300; i++) begin
      logic [1:0] c;
      c = encode(1'($urandom));
      send_burst(c, int'(enc_st));
    end
    @(negedge clk);
    in_valid = 1'b0;

    // gaps with garbage on in_sym: nothing may move (R8, R7)
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      in_sym = 2'($urandom);
      check(out_valid == 1'b0 || i == 0, "R7 idle out_valid", int'(out_valid), 0);
    end

    // all-zero and all-one patterns, many ties (R4)
    for (int i = 0; i < 40; i++) send(2'b00, -1);
    for (int i = 0; i < 40; i++) send(2'b11, -1);
    for (int i = 0; i < 40; i++) send((i % 2) ? 2'b10 : 2'b01, -1);

    // long noisy stream with random idle gaps (R9)
    for (int i = 0; i < 2000; i++) begin
      logic [1:0] c;
      c = encode(1'($urandom));
      if (($urandom % 8) == 0) c[0] = ~c[0];
      if (($urandom % 8) == 0) c[1] = ~c[1];
      if (($urandom % 3) == 0) send(c, -1);
      else send_burst(c, -1);
    end
    @(negedge clk);
    in_valid = 1'b0;

    // reset in the middle, then resume (R11, R6)
    send(2'b10, -1);
    @(negedge clk);
    @(negedge clk);
    do_reset();
    send(2'b01, -1);
    send(2'b11, -1);

    repeat (4) @(negedge clk);
    check(q_dec.size() == 0, "R7 all results delivered", q_dec.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule